// File: doc/BRIEF.md
# Serial Transceiver with Frame-Exact Idle Flags

This block is an asynchronous serial transmitter and receiver pair for byte traffic. The transmitter takes one byte at a time from a write port and sends it as a frame. The receiver rebuilds bytes from the serial input and holds each one on a read port until the consumer takes it. The frame has a low start bit, eight data bits sent least significant bit first, an optional even parity bit and one or two high stop bits. Two control inputs select the parity and stop-bit options. Each side latches them when a frame starts.

The status flags are exact to the frame. The transmit-idle flag rises only once the last stop bit has fully ended. The receive-idle flag stays low through the stop interval whenever another start bit follows directly. A disable request lets the frame in flight finish before the stopped state is reported. Bit timing uses a divider of `CLK_DIV` clocks per oversample tick and `OVERSAMPLE` ticks per bit. Each side restarts its divider at its own frame start, so frame edges land on known clock cycles.

Top module: `uart_idle_top`

## Requirements
- R1: After reset `txd` is high, `wr_ready` is 1 and `rd_valid` is 0. `status` reads 4'b0011, where bit 0 is receiver idle, bit 1 is transmitter idle, bit 2 is transmitter stopped and bit 3 is the sticky receive error.
- R2: A frame is a low start bit, then data bits 0 to 7 in that order, then an even parity bit when `cfg_parity_en` is 1, then the stop bits at high level. The parity bit equals the XOR of the eight data bits. The receiver returns the same byte on `rd_data` with `rd_valid` set.
- R3: Transmit idle (status bit 1) is low from the clock edge that accepts a write until the final stop bit has ended. It rises exactly N*OVERSAMPLE*CLK_DIV cycles after the accepting edge, where N = 10 + parity enable + two-stop select.
- R4: `cfg_two_stop` = 0 gives one stop bit and 1 gives two. Both the transmitter and the receiver use the value latched at frame start, and every idle flag waits out the whole stop period.
- R5: While `cfg_tx_off` is 1, a frame in progress completes with all its stop bits. Status bit 2 then rises together with bit 1. While stopped, `wr_ready` is 0, writes are ignored and `txd` stays high. When `cfg_tx_off` returns to 0, the stopped flag clears and `wr_ready` returns within two cycles.
- R6: `wr_ready` is 1 only when a write will be taken. A write presented while a frame is being sent is dropped: the frame in flight is unchanged and no second frame follows.
- R7: Receive idle (status bit 0) falls within 3 clock cycles of `rxd` falling while idle. It stays low across the stop interval when a new start bit follows directly. It rises only after the full stop period, 3 cycles after the line's stop period ends.
- R8: A parity mismatch or a low sample in any stop bit sets status bit 3. The byte is still delivered. `rd_valid` and status bit 3 hold until a cycle with `rd_take` high clears them. A frame completing in that same cycle takes precedence.
- R9: A low pulse on `rxd` that has ended by the middle of the start bit is rejected. No byte is delivered, and receive idle returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_parity_en | input | 1 | 1: add and check an even parity bit |
| cfg_tx_off | input | 1 | Request the transmitter to stop after the current frame |
| wr_en | input | 1 | Write strobe for a byte to send |
| wr_data | input | DATA_W | Byte to send |
| wr_ready | output | 1 | A write in this cycle will be accepted |
| rd_take | input | 1 | Consume the received byte and clear the error flag |
| rd_data | output | DATA_W | Last received byte |
| rd_valid | output | 1 | A received byte is waiting |
| status | output | 4 | {rx error, tx stopped, tx idle, rx idle} |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The bench goes after the exact cycle in which transmit idle rises, for every mix of parity and stop length. A transmitter that raised idle when the stop bit began would be caught 16 or 32 ticks early, and one that skipped the second stop bit would fail the frame length. Two received frames are driven back to back while the bench watches receive idle. A receiver that reported idle during the stop bit would show a high blip right before the second start. A disable request is raised in the middle of a frame, and the bench checks that the frame still decodes whole and that the stopped flag waits for the stop bits. Short low glitches, bad parity and a low first stop bit then test that false starts are dropped and that the error flag stays set until the byte is taken.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_START = 3'd1,
        TX_DATA  = 3'd2,
        TX_PAR   = 3'd3,
        TX_STOP  = 3'd4,
        TX_OFF   = 3'd5
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4,
        RX_TAIL  = 3'd5
    } rx_state_e;

    localparam int STAT_W      = 4;
    localparam int ST_RX_IDLE  = 0;
    localparam int ST_TX_IDLE  = 1;
    localparam int ST_TX_OFF   = 2;
    localparam int ST_RX_ERR   = 3;

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || cnt_q == LAST) cnt_d = '0;
        else                          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R3: ticks are spaced, so bit timing counts whole divider periods
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_idle_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cfg_parity,
    input  logic          cfg_two_stop,
    input  logic          cfg_off,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          restart,
    output logic          wr_ready,
    output logic          txd,
    output logic          tx_idle,
    output logic          tx_off_stat
);
    localparam int TW = $clog2(OSR);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [TW-1:0] T_LAST   = TW'(OSR - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [TW-1:0] tcnt;
        logic [BW-1:0] bidx;
        logic          second;
        logic [DW-1:0] sh;
        logic          par;
        logic          pe;
        logic          ts;
        logic          txd;
    } tx_reg_t;

    tx_reg_t d, q;

    always_comb begin
        d       = q;
        restart = 1'b0;
        case (q.st)
            TX_IDLE: begin
                if (cfg_off) begin
                    d.st = TX_OFF;
                end else if (wr_en) begin
                    d.st    = TX_START;
                    d.sh    = wr_data;
                    d.par   = ^wr_data;
                    d.pe    = cfg_parity;
                    d.ts    = cfg_two_stop;
                    d.tcnt  = '0;
                    d.txd   = 1'b0;
                    restart = 1'b1;
                end
            end
            TX_OFF: begin
                if (!cfg_off) d.st = TX_IDLE;
            end
            default: begin
                if (tick) begin
                    if (q.tcnt != T_LAST) begin
                        d.tcnt = q.tcnt + 1'b1;
                    end else begin
                        d.tcnt = '0;
                        case (q.st)
                            TX_START: begin
                                d.st   = TX_DATA;
                                d.bidx = '0;
                                d.txd  = q.sh[0];
                            end
                            TX_DATA: begin
                                if (q.bidx == BIT_LAST) begin
                                    d.st     = q.pe ? TX_PAR : TX_STOP;
                                    d.txd    = q.pe ? q.par : 1'b1;
                                    d.second = 1'b0;
                                end else begin
                                    d.bidx = q.bidx + 1'b1;
                                    d.sh   = q.sh >> 1;
                                    d.txd  = q.sh[1];
                                end
                            end
                            TX_PAR: begin
                                d.st     = TX_STOP;
                                d.txd    = 1'b1;
                                d.second = 1'b0;
                            end
                            TX_STOP: begin
                                if (q.ts && !q.second) d.second = 1'b1;
                                else                   d.st = cfg_off ? TX_OFF : TX_IDLE;
                            end
                            default: d.st = TX_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd         = q.txd;
    assign tx_idle     = (q.st == TX_IDLE) || (q.st == TX_OFF);
    assign tx_off_stat = (q.st == TX_OFF);
    assign wr_ready    = (q.st == TX_IDLE) && !cfg_off;

    // R3: a low line always means a frame is on the wire
    a_r3_low_line_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> !tx_idle);
    // R5: the stopped transmitter holds the line at the idle level
    a_r5_off_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_off_stat |-> txd);
    // R5: stopping is only reported after a high stop level
    a_r5_off_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_off_stat) |-> $past(txd));
    // R6: no write is offered while a frame is in flight
    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |-> !wr_ready);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_idle_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          cfg_parity,
    input  logic          cfg_two_stop,
    input  logic          rd_take,
    output logic          restart,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rx_idle,
    output logic          rx_err
);
    localparam int TW = $clog2(OSR);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [TW-1:0] T_LAST   = TW'(OSR - 1);
    localparam logic [TW-1:0] H_LAST   = TW'(OSR / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [TW-1:0] tcnt;
        logic [BW-1:0] bidx;
        logic          second;
        logic [DW-1:0] sh;
        logic          pe;
        logic          ts;
        logic          bad;
        logic          s1;
        logic          s2;
        logic [DW-1:0] data;
        logic          valid;
        logic          err;
    } rx_reg_t;

    rx_reg_t d, q;

    always_comb begin
        d       = q;
        restart = 1'b0;
        d.s1    = rxd;
        d.s2    = q.s1;
        if (rd_take) begin
            d.valid = 1'b0;
            d.err   = 1'b0;
        end
        case (q.st)
            RX_IDLE, RX_TAIL: begin
                if (!q.s2) begin
                    d.st    = RX_START;
                    d.tcnt  = '0;
                    d.pe    = cfg_parity;
                    d.ts    = cfg_two_stop;
                    d.bad   = 1'b0;
                    restart = 1'b1;
                end else if (q.st == RX_TAIL && tick) begin
                    if (q.tcnt == H_LAST) d.st = RX_IDLE;
                    else                  d.tcnt = q.tcnt + 1'b1;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.tcnt == H_LAST) begin
                        d.tcnt = '0;
                        if (q.s2) begin
                            d.st = RX_IDLE;
                        end else begin
                            d.st   = RX_DATA;
                            d.bidx = '0;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.tcnt != T_LAST) begin
                        d.tcnt = q.tcnt + 1'b1;
                    end else begin
                        d.tcnt = '0;
                        case (q.st)
                            RX_DATA: begin
                                d.sh = {q.s2, q.sh[DW-1:1]};
                                if (q.bidx == BIT_LAST) begin
                                    d.st     = q.pe ? RX_PAR : RX_STOP;
                                    d.second = 1'b0;
                                end else begin
                                    d.bidx = q.bidx + 1'b1;
                                end
                            end
                            RX_PAR: begin
                                d.bad    = q.bad | (^q.sh ^ q.s2);
                                d.st     = RX_STOP;
                                d.second = 1'b0;
                            end
                            RX_STOP: begin
                                if (q.ts && !q.second) begin
                                    d.second = 1'b1;
                                    d.bad    = q.bad | !q.s2;
                                end else begin
                                    d.st    = RX_TAIL;
                                    d.data  = q.sh;
                                    d.valid = 1'b1;
                                    d.err   = d.err | q.bad | !q.s2;
                                end
                            end
                            default: d.st = RX_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_data  = q.data;
    assign rd_valid = q.valid;
    assign rx_idle  = (q.st == RX_IDLE);
    assign rx_err   = q.err;

    // R7: a synchronized low level while idle ends the idle report next cycle
    a_r7_start_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_IDLE && !q.s2) |=> !rx_idle);
    // R7: a byte is delivered mid-stop, so the receiver is not yet idle
    a_r7_deliver_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> !rx_idle);
    // R8: taking the byte clears the error unless a new frame landed
    a_r8_take_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> (!rx_err || rd_valid));
    // R9: a start bit that is high again at mid-bit returns to idle
    a_r9_glitch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && tick && q.tcnt == H_LAST && q.s2) |=> rx_idle);

endmodule

// File: rtl/uart_idle_top.sv
module uart_idle_top
    import uart_idle_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_two_stop,
    input  logic              cfg_parity_en,
    input  logic              cfg_tx_off,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [STAT_W-1:0] status,
    output logic              txd,
    input  logic              rxd
);
    localparam int N_SIDES = 2;

    logic [N_SIDES-1:0] side_restart;
    logic [N_SIDES-1:0] side_tick;
    logic tx_idle, tx_off_stat, rx_idle, rx_err;

    generate
        for (genvar g = 0; g < N_SIDES; g++) begin : g_tick
            uart_baud_tick #(.DIV(CLK_DIV)) u_tick (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (side_restart[g]),
                .tick    (side_tick[g])
            );
        end
    endgenerate

    uart_tx_core #(.DW(DATA_W), .OSR(OVERSAMPLE)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (side_tick[0]),
        .cfg_parity   (cfg_parity_en),
        .cfg_two_stop (cfg_two_stop),
        .cfg_off      (cfg_tx_off),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .restart      (side_restart[0]),
        .wr_ready     (wr_ready),
        .txd          (txd),
        .tx_idle      (tx_idle),
        .tx_off_stat  (tx_off_stat)
    );

    uart_rx_core #(.DW(DATA_W), .OSR(OVERSAMPLE)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (side_tick[1]),
        .rxd          (rxd),
        .cfg_parity   (cfg_parity_en),
        .cfg_two_stop (cfg_two_stop),
        .rd_take      (rd_take),
        .restart      (side_restart[1]),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rx_idle      (rx_idle),
        .rx_err       (rx_err)
    );

    always_comb begin
        status             = '0;
        status[ST_RX_IDLE] = rx_idle;
        status[ST_TX_IDLE] = tx_idle;
        status[ST_TX_OFF]  = tx_off_stat;
        status[ST_RX_ERR]  = rx_err;
    end

    // R1: the stopped flag is never raised while the transmitter is busy
    a_r1_off_implies_idle: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TX_OFF] |-> status[ST_TX_IDLE]);

endmodule

// File: tb/uart_idle_top_bench.sv
module uart_idle_top_bench;
    localparam int DIV = 2;
    localparam int OSR = 16;
    localparam int BIT = DIV * OSR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_two_stop = 1'b0, cfg_parity_en = 1'b0, cfg_tx_off = 1'b0;
    logic wr_en = 1'b0, rd_take = 1'b0, rxd = 1'b1;
    logic [7:0] wr_data = '0;
    logic wr_ready, rd_valid, txd;
    logic [7:0] rd_data;
    logic [3:0] status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_idle_top #(.CLK_DIV(DIV), .OVERSAMPLE(OSR), .DATA_W(8)) u_uart_idle_top (
        .clk(clk), .rst_n(rst_n), .cfg_two_stop(cfg_two_stop),
        .cfg_parity_en(cfg_parity_en), .cfg_tx_off(cfg_tx_off),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_take(rd_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status), .txd(txd), .rxd(rxd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int frame_bits(input bit pe, input bit ts);
        return 10 + int'(pe) + int'(ts);
    endfunction

    task automatic tx_frame(input logic [7:0] b, input bit pe, input bit ts,
                            input bit poke, input bit dis);
        logic line [0:15];
        int n, c, rise;
        bit early, quiet;
        logic [7:0] got;
        n = frame_bits(pe, ts);
        rise = 0;
        early = 1'b0;
        for (int k = 0; k < 16; k++) line[k] = 1'b1;
        @(negedge clk);
        cfg_parity_en = pe; cfg_two_stop = ts; cfg_tx_off = 1'b0;
        chk(wr_ready == 1'b1, "R6 ready before write", int'(wr_ready), 1);
        wr_data = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        c = 1;
        while (c <= 13 * BIT + 4 && rise == 0) begin
            if (status[1]) rise = c;
            if ((c % BIT) == BIT / 2 && (c / BIT) < 16) line[c / BIT] = txd;
            if (poke) begin
                wr_en = (c == 40);
                wr_data = ~b;
                if (c == 40) chk(wr_ready == 1'b0, "R6 not ready while busy", int'(wr_ready), 0);
            end
            if (dis && c == 60) cfg_tx_off = 1'b1;
            if (!status[1] && status[2]) early = 1'b1;
            @(negedge clk);
            c++;
        end
        wr_en = 1'b0;
        chk(rise == n * BIT + 1, "R3 tx idle rise cycle", rise, n * BIT + 1);
        chk(line[0] == 1'b0, "R2 start bit low", int'(line[0]), 0);
        got = '0;
        for (int i = 0; i < 8; i++) got[i] = line[1 + i];
        chk(got == b, "R2 data bits LSB first", int'(got), int'(b));
        if (pe) chk(line[9] == ^b, "R2 even parity bit", int'(line[9]), int'(^b));
        chk(line[9 + int'(pe)] == 1'b1, "R4 first stop high", int'(line[9 + int'(pe)]), 1);
        if (ts) chk(line[10 + int'(pe)] == 1'b1, "R4 second stop high", int'(line[10 + int'(pe)]), 1);
        chk(!early, "R5 stopped flag not early", int'(early), 0);
        chk(status[2] == dis, "R5 stopped flag at frame end", int'(status[2]), int'(dis));
        if (poke) begin
            quiet = 1'b1;
            repeat (100) begin
                @(negedge clk);
                if (!txd || !status[1]) quiet = 1'b0;
            end
            chk(quiet, "R6 busy write dropped", int'(quiet), 1);
        end
        if (dis) begin
            chk(wr_ready == 1'b0, "R5 not ready while stopped", int'(wr_ready), 0);
            wr_data = 8'h3C; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
            quiet = 1'b1;
            repeat (100) begin
                @(negedge clk);
                if (!txd || !status[2]) quiet = 1'b0;
            end
            chk(quiet, "R5 write ignored while stopped", int'(quiet), 1);
            cfg_tx_off = 1'b0;
            repeat (2) @(negedge clk);
            chk(wr_ready == 1'b1, "R5 ready after re-enable", int'(wr_ready), 1);
            chk(status[2] == 1'b0, "R5 stopped flag cleared", int'(status[2]), 0);
        end
    endtask

    task automatic rx_send(input logic [7:0] b, input bit pe, input bit ts,
                           input bit bad_par, input bit bad_stop,
                           output bit saw_idle, output bit drop_ok);
        logic bits [0:15];
        int n, cyc, idx;
        n = frame_bits(pe, ts);
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[1 + i] = b[i];
        idx = 9;
        if (pe) begin
            bits[9] = (^b) ^ bad_par;
            idx = 10;
        end
        bits[idx] = !bad_stop;
        if (ts) bits[idx + 1] = 1'b1;
        cfg_parity_en = pe; cfg_two_stop = ts;
        saw_idle = 1'b0;
        drop_ok = 1'b0;
        cyc = 0;
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < BIT; j++) begin
                rxd = bits[k];
                @(negedge clk);
                cyc++;
                if (cyc == 3) drop_ok = !status[0];
                if (cyc >= 3 && status[0]) saw_idle = 1'b1;
            end
        end
        rxd = 1'b1;
    endtask

    task automatic rx_check(input logic [7:0] b, input bit err);
        repeat (12) @(negedge clk);
        chk(status[0] == 1'b1, "R7 rx idle after stop period", int'(status[0]), 1);
        chk(rd_valid == 1'b1, "R2 byte delivered", int'(rd_valid), 1);
        chk(rd_data == b, "R2 received byte", int'(rd_data), int'(b));
        chk(status[3] == err, "R8 error flag", int'(status[3]), int'(err));
        rd_take = 1'b1;
        @(negedge clk);
        rd_take = 1'b0;
        chk(rd_valid == 1'b0, "R8 take clears valid", int'(rd_valid), 0);
        chk(status[3] == 1'b0, "R8 take clears error", int'(status[3]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb, rb2;
        bit rpe, rts, saw, drop, saw2, drop2;
        int seed;
        seed = int'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(txd == 1'b1, "R1 line high in reset", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 4'b0011, "R1 status after reset", int'(status), 3);
        chk(wr_ready == 1'b1, "R1 ready after reset", int'(wr_ready), 1);
        chk(rd_valid == 1'b0, "R1 no byte after reset", int'(rd_valid), 0);
        chk(txd == 1'b1, "R1 line high after reset", int'(txd), 1);

        // transmitter: all frame options and the extreme bytes
        tx_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        tx_frame(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
        tx_frame(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0);
        tx_frame(8'h37, 1'b1, 1'b1, 1'b0, 1'b0);
        tx_frame(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
        tx_frame(8'hC3, 1'b1, 1'b1, 1'b0, 1'b1);
        tx_frame(8'h81, 1'b0, 1'b1, 1'b1, 1'b1);

        // receiver: plain frames, back-to-back pairs, errors, glitch
        rx_send(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, saw, drop);
        chk(drop, "R7 rx idle drops at start", int'(drop), 1);
        chk(!saw, "R7 rx idle low through frame", int'(saw), 0);
        rx_check(8'h96, 1'b0);
        rx_send(8'h11, 1'b1, 1'b1, 1'b0, 1'b0, saw, drop);
        rx_send(8'hEE, 1'b1, 1'b1, 1'b0, 1'b0, saw2, drop2);
        chk(!saw && !saw2, "R7 rx idle low across back-to-back stop", int'(saw | saw2), 0);
        rx_check(8'hEE, 1'b0);
        rx_send(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, saw, drop);
        rx_send(8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, saw2, drop2);
        chk(!saw && !saw2, "R7 one-stop back-to-back idle low", int'(saw | saw2), 0);
        rx_check(8'hF0, 1'b0);
        rx_send(8'h6B, 1'b1, 1'b0, 1'b1, 1'b0, saw, drop);
        rx_check(8'h6B, 1'b1);
        rx_send(8'h24, 1'b0, 1'b1, 1'b0, 1'b1, saw, drop);
        rx_check(8'h24, 1'b1);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk(status[0] == 1'b1, "R9 idle after glitch", int'(status[0]), 1);
        chk(rd_valid == 1'b0, "R9 no byte from glitch", int'(rd_valid), 0);

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            rb = 8'($urandom);
            rb2 = 8'($urandom);
            rpe = 1'($urandom);
            rts = 1'($urandom);
            case ($urandom % 3)
                0: tx_frame(rb, rpe, rts, 1'b0, 1'b0);
                1: begin
                    rx_send(rb, rpe, rts, 1'b0, 1'b0, saw, drop);
                    chk(drop && !saw, "R7 random rx idle", int'(saw), 0);
                    rx_check(rb, 1'b0);
                end
                default: begin
                    rx_send(rb, rpe, rts, 1'b0, 1'b0, saw, drop);
                    rx_send(rb2, rpe, rts, rpe, 1'b0, saw2, drop2);
                    chk(!saw && !saw2, "R7 random back-to-back idle", int'(saw | saw2), 0);
                    rx_check(rb2, rpe);
                end
            endcase
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule